// File: doc/BRIEF.md
# Two-Core Interrupt Distributor With Legacy Pass-Through

This block collects interrupt requests for a small processor cluster (two cores by default) and chooses, for each core, the most urgent request that is pending, enabled, not already being serviced, and allowed by that core's mask. It handles three kinds of source:
- Software-raised requests on IDs 0 to 15, kept in a separate copy for each core.
- Five per-core peripheral lines on IDs 27 to 31.
- Shared peripheral lines starting at ID 32, each of which can be routed to any subset of cores.

Software works the block through a single valid/write/address/data request port. The `req_core` field says which core is making the access, and so which per-core copy of the banked state is used. A read of the acknowledge address returns the winning ID and marks that interrupt active. A write of the same ID to the end-of-interrupt address releases it.

Each core has an interface enable. While the enable is clear, that core's legacy FIQ and IRQ pins drive its `fiq_o` and `irq_o` outputs directly. While it is set, those two pins become ordinary sources 28 and 31, `fiq_o` stays low, and `irq_o` carries the distributor's registered request.

Top module: `irq_distributor`

## Requirements
- R1: After reset, every interface enable, priority mask, enable bit, pending, active and priority value is zero, and `rsp_valid` is low. With all pins low, `irq_o`, `fiq_o` and `irq_id_o` are therefore zero.
- R2: While a core's interface enable (address 0x00, bit 0, written by that core) is clear, its `fiq_o` equals its legacy FIQ pin (`ppi_i` bit 1 of its group) and its `irq_o` equals its legacy IRQ pin (bit 4 of its group) in the same cycle.
- R3: While a core's interface enable is set, its `fiq_o` is low and its legacy FIQ and IRQ pins act as level sources with IDs 28 and 31. Per-core group bits 0, 2 and 3 are IDs 27, 29 and 30.
- R4: A write to 0x04 raises software ID `wdata[3:0]` in the bank of every core whose bit is set at `wdata[16+c]`. Acknowledging it returns the ID in `rsp_data[9:0]` and the requesting core's number from bit 10 upward.
- R5: A software-raised request is ranked by the receiving core's own priority for that ID. Priorities are written at 0x40+ID; values for IDs below 32 are banked by `req_core`.
- R6: Among eligible sources, the lowest priority value wins, and equal values go to the lower ID.
- R7: A source competes only if its priority is strictly below the core's mask, which is written at 0x01 using `wdata[7:0]`.
- R8: A shared line n reaches core c only if bit c of its target mask is set. The target mask is written at 0x80+n using `wdata[NCORE-1:0]`.
- R9: A shared line configured as rising-edge (bit n = 1 at 0x07) latches pending on a 0-to-1 transition. The latch holds after the line falls, clears on acknowledge, and does not return after end-of-interrupt.
- R10: A level shared line (bit n = 0 at 0x07) is pending only while high. After end-of-interrupt (0x03, `wdata[9:0]` = ID) with the line still high, it is acknowledged again.
- R11: A read of the acknowledge address 0x02 with nothing eligible returns 1023. Every read gives `rsp_valid` one cycle later. An active source is not offered again until its end-of-interrupt.
- R12: A source competes only with its enable bit set. Banked IDs 0 to 31 are enabled at 0x05 (bit = ID, banked by `req_core`); shared lines are enabled at 0x06 (bit n).
- R13: `irq_o` (with the interface enabled) and `irq_id_o` are registered: they reflect eligibility one clock after the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_core | input | CW | Core making the access (selects the bank) |
| req_addr | input | 8 | Register address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle after a read |
| rsp_data | output | 32 | Read data (acknowledge word) |
| ppi_i | input | NCORE*5 | Per-core peripheral lines, 5 bits per core |
| spi_i | input | NSPI | Shared peripheral lines |
| fiq_o | output | NCORE | Per-core FIQ request |
| irq_o | output | NCORE | Per-core IRQ request |
| irq_id_o | output | NCORE*10 | Per-core winning ID, registered |

## Verification
A vector table drives eight patterns onto the shared lines, which carry a staggered set of priorities:
- A single line checks the ID mapping.
- Mixed priorities check that the lowest value wins.
- Equal priorities check that the lower ID wins.
- An empty pattern checks the spurious code.

Directed sequences then cover the remaining behaviour:
- Software requests are raised by one core for another with conflicting banked priorities, which separates the receiver's priority from the sender's and exposes the recorded source number.
- A pulse on an edge line is compared with a held level line through acknowledge and end-of-interrupt, which separates latching from tracking.
- Mask, enable and target settings are each set just beyond their threshold.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int IDW       = 10;
  localparam int SPURIOUS  = 1023;
  localparam int NBANK     = 32;
  localparam int NSGI      = 16;
  localparam int PPI_BASE  = 27;
  localparam int NPPI      = 5;
  localparam int SPI_BASE  = 32;

  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_PMASK = 8'h01;
  localparam logic [7:0] A_ACK   = 8'h02;
  localparam logic [7:0] A_EOI   = 8'h03;
  localparam logic [7:0] A_SGI   = 8'h04;
  localparam logic [7:0] A_ENB   = 8'h05;
  localparam logic [7:0] A_ENS   = 8'h06;
  localparam logic [7:0] A_TRIG  = 8'h07;
endpackage

// File: rtl/irqd_spi_state.sv
module irqd_spi_state #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] edge_mode_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] latch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= line_i;
      latch_q <= edge_mode_i & ((latch_q & ~clr_i) | (line_i & ~prev_q));
    end
  end

  for (genvar n = 0; n < N; n++) begin : g_sel
    assign pend_o[n] = edge_mode_i[n] ? latch_q[n] : line_i[n];
  end
endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter #(
  parameter int NID = 64,
  parameter int PW  = 8,
  parameter int IDW = 10
) (
  input  logic [NID-1:0]         elig_i,
  input  logic [NID-1:0][PW-1:0] prio_i,
  input  logic [PW-1:0]          mask_i,
  output logic                   valid_o,
  output logic [IDW-1:0]         id_o
);
  logic [PW-1:0] best;

  always_comb begin
    valid_o = 1'b0;
    best    = '1;
    id_o    = '0;
    for (int i = 0; i < NID; i++) begin
      if (elig_i[i] && (prio_i[i] < mask_i) && (!valid_o || prio_i[i] < best)) begin
        valid_o = 1'b1;
        best    = prio_i[i];
        id_o    = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irqd_pkg::*;
#(
  parameter int NCORE = 2,
  parameter int NSPI  = 32,
  parameter int PW    = 8,
  localparam int CW   = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [CW-1:0]          req_core,
  input  logic [7:0]             req_addr,
  input  logic [31:0]            req_wdata,
  output logic                   rsp_valid,
  output logic [31:0]            rsp_data,
  input  logic [NCORE*NPPI-1:0]  ppi_i,
  input  logic [NSPI-1:0]        spi_i,
  output logic [NCORE-1:0]       fiq_o,
  output logic [NCORE-1:0]       irq_o,
  output logic [NCORE*IDW-1:0]   irq_id_o
);
  localparam int NID = SPI_BASE + NSPI;

  // banked (per core) state
  logic [NCORE-1:0]                     ien_q;
  logic [NCORE-1:0][PW-1:0]             pmask_q;
  logic [NCORE-1:0][NBANK-1:0]          en_b_q;
  logic [NCORE-1:0][NBANK-1:0]          act_b_q;
  logic [NCORE-1:0][NSGI-1:0]           sgi_pend_q;
  logic [NCORE-1:0][NSGI-1:0][CW-1:0]   sgi_src_q;
  logic [NCORE-1:0][NBANK-1:0][PW-1:0]  prio_b_q;
  // shared state
  logic [NSPI-1:0][PW-1:0]              prio_s_q;
  logic [NSPI-1:0][NCORE-1:0]           tgt_q;
  logic [NSPI-1:0]                      en_s_q;
  logic [NSPI-1:0]                      trig_q;
  logic [NSPI-1:0]                      spi_act_q;
  logic [NSPI-1:0]                      spi_pend;
  logic [NSPI-1:0]                      spi_clr;

  logic [NCORE-1:0]                     win_v;
  logic [NCORE-1:0][IDW-1:0]            win_id;
  logic [NCORE-1:0]                     irq_q;
  logic [NCORE-1:0][IDW-1:0]            irq_id_q;

  logic             wr, rd, ack, eoi;
  logic             sel_v;
  logic [IDW-1:0]   sel_id;
  logic [IDW-1:0]   eoi_id;
  logic [31:0]      ack_word;
  logic             rsp_valid_q;
  logic [31:0]      rsp_data_q;

  assign wr     = req_valid && req_write;
  assign rd     = req_valid && !req_write;
  assign ack    = rd && (req_addr == A_ACK);
  assign eoi    = wr && (req_addr == A_EOI);
  assign eoi_id = req_wdata[IDW-1:0];
  assign sel_v  = win_v[req_core];
  assign sel_id = win_id[req_core];

  always_comb begin
    ack_word = 32'(SPURIOUS);
    if (sel_v) begin
      ack_word = 32'(sel_id);
      if (sel_id < IDW'(NSGI))
        ack_word[IDW +: CW] = sgi_src_q[req_core][sel_id[3:0]];
    end
  end

  always_comb begin
    spi_clr = '0;
    for (int n = 0; n < NSPI; n++)
      if (ack && sel_v && sel_id == IDW'(SPI_BASE + n)) spi_clr[n] = 1'b1;
  end

  // per-core banked registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q      <= '0;
      pmask_q    <= '0;
      en_b_q     <= '0;
      act_b_q    <= '0;
      sgi_pend_q <= '0;
      sgi_src_q  <= '0;
      prio_b_q   <= '0;
    end else begin
      for (int c = 0; c < NCORE; c++) begin
        if (wr && req_core == CW'(c)) begin
          case (req_addr)
            A_CTRL:  ien_q[c]   <= req_wdata[0];
            A_PMASK: pmask_q[c] <= req_wdata[PW-1:0];
            A_ENB:   en_b_q[c]  <= req_wdata;
            default: ;
          endcase
          if (req_addr[7:6] == 2'b01 && !req_addr[5])
            prio_b_q[c][req_addr[4:0]] <= req_wdata[PW-1:0];
          if (eoi && eoi_id < IDW'(NBANK))
            act_b_q[c][eoi_id[4:0]] <= 1'b0;
        end
        if (wr && req_addr == A_SGI && req_wdata[16+c]) begin
          sgi_pend_q[c][req_wdata[3:0]] <= 1'b1;
          sgi_src_q[c][req_wdata[3:0]]  <= req_core;
        end
        if (ack && req_core == CW'(c) && win_v[c] && win_id[c] < IDW'(NBANK)) begin
          act_b_q[c][win_id[c][4:0]] <= 1'b1;
          if (win_id[c] < IDW'(NSGI)) sgi_pend_q[c][win_id[c][3:0]] <= 1'b0;
        end
      end
    end
  end

  // shared registers
  always_ff @(posedge clk) begin
    if (rst) begin
      prio_s_q  <= '0;
      tgt_q     <= '0;
      en_s_q    <= '0;
      trig_q    <= '0;
      spi_act_q <= '0;
    end else begin
      if (wr && req_addr == A_ENS)  en_s_q <= req_wdata[NSPI-1:0];
      if (wr && req_addr == A_TRIG) trig_q <= req_wdata[NSPI-1:0];
      for (int n = 0; n < NSPI; n++) begin
        if (wr && req_addr == 8'(8'h40 + SPI_BASE + n)) prio_s_q[n] <= req_wdata[PW-1:0];
        if (wr && req_addr == 8'(8'h80 + n))            tgt_q[n]    <= req_wdata[NCORE-1:0];
        if (eoi && eoi_id == IDW'(SPI_BASE + n))         spi_act_q[n] <= 1'b0;
        if (spi_clr[n])                                  spi_act_q[n] <= 1'b1;
      end
    end
  end

  irqd_spi_state #(.N(NSPI)) u_spi (
    .clk(clk), .rst(rst), .line_i(spi_i), .edge_mode_i(trig_q),
    .clr_i(spi_clr), .pend_o(spi_pend)
  );

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic [NID-1:0]         elig;
    logic [NID-1:0][PW-1:0] pview;

    always_comb begin
      for (int i = 0; i < NSGI; i++) begin
        elig[i]  = sgi_pend_q[c][i] & en_b_q[c][i] & ~act_b_q[c][i];
        pview[i] = prio_b_q[c][i];
      end
      for (int i = NSGI; i < PPI_BASE; i++) begin
        elig[i]  = 1'b0;
        pview[i] = prio_b_q[c][i];
      end
      for (int k = 0; k < NPPI; k++) begin
        elig[PPI_BASE+k]  = ppi_i[c*NPPI+k] & en_b_q[c][PPI_BASE+k] & ~act_b_q[c][PPI_BASE+k];
        pview[PPI_BASE+k] = prio_b_q[c][PPI_BASE+k];
      end
      for (int n = 0; n < NSPI; n++) begin
        elig[SPI_BASE+n]  = spi_pend[n] & en_s_q[n] & ~spi_act_q[n] & tgt_q[n][c];
        pview[SPI_BASE+n] = prio_s_q[n];
      end
    end

    irqd_arbiter #(.NID(NID), .PW(PW), .IDW(IDW)) u_arb (
      .elig_i(elig), .prio_i(pview), .mask_i(pmask_q[c]),
      .valid_o(win_v[c]), .id_o(win_id[c])
    );

    assign fiq_o[c] = ien_q[c] ? 1'b0     : ppi_i[c*NPPI+1];
    assign irq_o[c] = ien_q[c] ? irq_q[c] : ppi_i[c*NPPI+4];
    assign irq_id_o[c*IDW +: IDW] = irq_id_q[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q       <= '0;
      irq_id_q    <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      irq_q       <= win_v;
      irq_id_q    <= win_id;
      rsp_valid_q <= rd;
      rsp_data_q  <= ack ? ack_word : 32'd0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker #(
  parameter int NCORE = 2,
  parameter int NSPI  = 32,
  parameter int PW    = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     req_valid,
  input logic                     req_write,
  input logic [7:0]               req_addr,
  input logic [31:0]              req_wdata,
  input logic                     rsp_valid,
  input logic [31:0]              rsp_data,
  input logic [NSPI-1:0]          spi_act_q,
  input logic [NCORE-1:0][PW-1:0] pmask_q,
  input logic [NCORE-1:0]         irq_q
);
  assert_read_responds_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid);

  assert_ack_marks_active_R11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_data[9:0] >= 10'd32 && rsp_data[9:0] < 10'(32 + NSPI))
      |-> spi_act_q[rsp_data[9:0] - 10'd32]);

  assert_eoi_releases_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr == 8'h03 &&
     req_wdata[9:0] >= 10'd32 && req_wdata[9:0] < 10'(32 + NSPI))
      |=> !spi_act_q[$past(req_wdata[9:0]) - 10'd32]);

  for (genvar c = 0; c < NCORE; c++) begin : g_mask
    assert_zero_mask_silent_R7: assert property (@(posedge clk) disable iff (rst)
      ($past(pmask_q[c]) == '0) |-> !irq_q[c]);
  end
endmodule

bind irq_distributor irqd_checker #(.NCORE(NCORE), .NSPI(NSPI), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_data(rsp_data), .spi_act_q(spi_act_q), .pmask_q(pmask_q), .irq_q(irq_q)
);

// File: tb/sim_irq_distributor.sv
`timescale 1ns/1ps
module sim_irq_distributor;
  localparam int NCORE = 2;
  localparam int NSPI  = 32;
  localparam int SPUR  = 1023;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [0:0]  req_core = '0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [9:0]  ppi_i = '0;
  logic [31:0] spi_i = '0;
  logic [1:0]  fiq_o, irq_o;
  logic [19:0] irq_id_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_distributor u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_core(req_core), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ppi_i(ppi_i), .spi_i(spi_i),
    .fiq_o(fiq_o), .irq_o(irq_o), .irq_id_o(irq_id_o)
  );

  // {shared line pattern, expected acknowledged ID}; line n priority = (n%4)*16+64
  localparam logic [41:0] VEC [8] = '{
    {32'h0000_0001, 10'd32},
    {32'h0000_0006, 10'd33},
    {32'h0000_0012, 10'd36},
    {32'h0001_0010, 10'd36},
    {32'h8000_0000, 10'd63},
    {32'h0000_0000, 10'd1023},
    {32'hC000_0000, 10'd62},
    {32'h0000_0A00, 10'd41}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int core, input int addr, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_core = 1'(core); req_addr = 8'(addr); req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic ack_chk(input string tag, input int core, input logic [31:0] exp);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_core = 1'(core); req_addr = 8'h02;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk(tag, rsp_data, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq_o", 32'(irq_o), 0);
    chk("R1 fiq_o", 32'(fiq_o), 0);
    chk("R1 irq_id_o", 32'(irq_id_o), 0);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    ack_chk("R11 spurious after reset", 0, SPUR);

    // R2 legacy pass-through on core 1
    @(negedge clk); ppi_i[6] = 1; ppi_i[9] = 1; #1;
    chk("R2 fiq pass", 32'(fiq_o[1]), 1);
    chk("R2 irq pass", 32'(irq_o[1]), 1);
    ppi_i[6] = 0; #1;
    chk("R2 fiq follows low", 32'(fiq_o[1]), 0);
    ppi_i[9] = 0;

    // configuration
    wr(0, 8'h00, 1); wr(1, 8'h00, 1);
    wr(0, 8'h01, 8'hFF); wr(1, 8'h01, 8'hFF);
    wr(0, 8'h06, 32'hFFFF_FFFF);
    wr(0, 8'h07, 0);
    for (int n = 0; n < NSPI; n++) begin
      wr(0, 8'h80 + n, 1);
      wr(0, 8'h40 + 32 + n, (n % 4) * 16 + 64);
    end

    // R6 table
    for (int v = 0; v < 8; v++) begin
      logic [31:0] exp;
      exp = 32'(VEC[v][9:0]);
      @(negedge clk); spi_i = VEC[v][41:10];
      idle(3);
      chk($sformatf("R6 vec%0d irq", v), 32'(irq_o[0]), (exp != SPUR) ? 1 : 0);
      if (exp != SPUR) chk($sformatf("R6 vec%0d irq_id", v), 32'(irq_id_o[9:0]), exp);
      ack_chk($sformatf("R6 vec%0d ack", v), 0, exp);
      spi_i = 0;
      if (exp != SPUR) wr(0, 8'h03, exp);
      idle(2);
    end

    // R3 legacy pins as IDs 28 and 31 on core 1
    wr(1, 8'h05, (32'd1 << 28) | (32'd1 << 31));
    wr(1, 8'h40 + 28, 10);
    wr(1, 8'h40 + 31, 5);
    @(negedge clk); ppi_i[6] = 1; ppi_i[9] = 1;
    idle(3);
    chk("R3 fiq low when enabled", 32'(fiq_o[1]), 0);
    chk("R3 irq from distributor", 32'(irq_o[1]), 1);
    ack_chk("R3 ack 31", 1, 31);
    ack_chk("R3 ack 28", 1, 28);
    ack_chk("R11 both active", 1, SPUR);
    ppi_i[6] = 0; ppi_i[9] = 0;
    wr(1, 8'h03, 31); wr(1, 8'h03, 28);

    // R4 / R5 software requests
    wr(0, 8'h05, (32'd1 << 5) | (32'd1 << 7));
    wr(1, 8'h05, (32'd1 << 5) | (32'd1 << 7));
    wr(0, 8'h40 + 5, 20); wr(0, 8'h40 + 7, 10);
    wr(1, 8'h40 + 5, 30); wr(1, 8'h40 + 7, 200);
    wr(0, 8'h04, 5 | (3 << 16));
    wr(1, 8'h04, 7 | (1 << 16));
    idle(2);
    ack_chk("R5 receiver priority, R4 source 1", 0, 32'h407);
    ack_chk("R4 core0 id5 source 0", 0, 5);
    ack_chk("R4 core1 id5", 1, 5);
    ack_chk("R4 core1 untargeted", 1, SPUR);
    wr(0, 8'h03, 7); wr(0, 8'h03, 5); wr(1, 8'h03, 5);

    // R7 mask strictly below
    wr(0, 8'h01, 64);
    @(negedge clk); spi_i[0] = 1;
    idle(3);
    chk("R7 masked irq", 32'(irq_o[0]), 0);
    ack_chk("R7 equal to mask", 0, SPUR);
    wr(0, 8'h01, 65);
    idle(3);
    ack_chk("R7 below mask", 0, 32);
    spi_i[0] = 0;
    wr(0, 8'h03, 32);
    wr(0, 8'h01, 8'hFF);

    // R8 target mask
    wr(0, 8'h80 + 3, 2);
    @(negedge clk); spi_i[3] = 1;
    idle(3);
    ack_chk("R8 not routed to core0", 0, SPUR);
    ack_chk("R8 routed to core1", 1, 35);
    spi_i[3] = 0;
    wr(1, 8'h03, 35);

    // R9 edge latch
    wr(0, 8'h07, 32'd1 << 5);
    @(negedge clk); spi_i[5] = 1;
    @(negedge clk); spi_i[5] = 0;
    idle(3);
    chk("R9 latched after pulse", 32'(irq_o[0]), 1);
    ack_chk("R9 ack edge", 0, 37);
    ack_chk("R9 cleared by ack", 0, SPUR);
    wr(0, 8'h03, 37);
    idle(3);
    ack_chk("R9 no return after eoi", 0, SPUR);

    // R10 level re-pend
    @(negedge clk); spi_i[6] = 1;
    idle(3);
    ack_chk("R10 ack level", 0, 38);
    ack_chk("R11 active not offered", 0, SPUR);
    wr(0, 8'h03, 38);
    idle(3);
    ack_chk("R10 re-pend after eoi", 0, 38);
    spi_i[6] = 0;
    wr(0, 8'h03, 38);
    idle(3);
    ack_chk("R10 gone when low", 0, SPUR);

    // R12 enable
    wr(0, 8'h06, 0);
    @(negedge clk); spi_i[0] = 1;
    idle(3);
    chk("R12 disabled irq", 32'(irq_o[0]), 0);
    ack_chk("R12 disabled ack", 0, SPUR);
    wr(0, 8'h06, 32'hFFFF_FFFF);
    idle(3);
    chk("R12 enabled irq", 32'(irq_o[0]), 1);
    spi_i[0] = 0;
    idle(3);

    // R13 one-cycle registered output
    @(negedge clk); spi_i[0] = 1; #1;
    chk("R13 not yet", 32'(irq_o[0]), 0);
    @(negedge clk);
    chk("R13 after one clock", 32'(irq_o[0]), 1);
    chk("R13 id", 32'(irq_id_o[9:0]), 32);
    spi_i[0] = 0;
    idle(2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule